// File: doc/BRIEF.md
# Railway Crossing Gate Controller

This block decides when the barriers of a road crossing must be down on a line that carries trains in both directions. Two presence detectors sit one on each side of the crossing, 400 m from it, so they are 800 m apart. Each detector output is high for as long as any part of a train is over it. The controller has one output, a request to hold the gates down. This request is high from the first sighting of a train until the tail of that train has cleared the detector on the far side.

Internally the controller stores the side the train entered from and one of four progress phases. These are: front over the entry detector only; train wholly between the detectors; train covering both detectors; tail past the entry detector but still over the far one. From these it handles trains shorter than the 800 m spacing, which leave both detectors idle for a while, and trains longer than the spacing, which hold both detectors high together. A far-side detector that goes high while a train is tracked never counts as a second train. Gate drive, warning lights and detector debouncing belong to other blocks.

Top module: `xing_gate_ctrl`

## Requirements
- R1: With rst_n low at a rising clock edge, gate_lower is 0 after that edge, and the controller forgets any train it was tracking.
- R2: While no train is tracked and det_a and det_b are both 0, gate_lower stays 0.
- R3: With no train tracked, det_a high at a clock edge makes gate_lower 1 after that edge, and the train is tracked as entering from side A.
- R4: With no train tracked, det_b high and det_a low at a clock edge makes gate_lower 1 after that edge, and the train is tracked as entering from side B.
- R5: A train shorter than the detector spacing keeps gate_lower at 1 through the cycles in which it sits between the detectors with both detectors at 0.
- R6: A train longer than the spacing, covering both detectors at once, keeps gate_lower at 1 and is not restarted as a new train when the far detector goes high.
- R7: gate_lower returns to 0 after the first clock edge that samples the far-side detector at 0 once it has been seen high. The entry detector going to 0 does not release the gates.
- R8: After a release, a new train from either side is accepted on the very next cycle.
- R9: When det_a and det_b both go high in the same cycle from idle, gate_lower goes to 1 and side A is taken as the entry side.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| det_a | input | 1 | Side A detector, 1 while a train is over it |
| det_b | input | 1 | Side B detector, 1 while a train is over it |
| gate_lower | output | 1 | 1 = gates must be down, 0 = gates may be up |

## Verification
The assertions assume that the detector levels describe one physical train at a time. The entry detector is the first to go high, and the far detector stays high until the tail has left it. They also assume the detectors are already synchronous to clk and free of bounce. The stimulus keeps to this by building every detector waveform from three cycle counts per train: front at the far detector, tail off the entry detector, and tail off the far detector. The tail always leaves the far detector last. Trains follow each other only after a full release, except for the reset case, which deliberately cuts a train short.

// File: rtl/xing_pkg.sv
// Shared types for the crossing gate controller.
// A tracked train is described by its entry side and a progress phase.
package xing_pkg;

    localparam int PH_W = 3;

    typedef enum logic {
        FROM_A = 1'b0,
        FROM_B = 1'b1
    } dir_e;

    typedef enum logic [PH_W-1:0] {
        PH_IDLE  = 3'd0,   // no train tracked
        PH_ENTER = 3'd1,   // front over entry detector, far detector not yet reached
        PH_GAP   = 3'd2,   // short train wholly between detectors
        PH_SPAN  = 3'd3,   // long train covering both detectors
        PH_EXIT  = 3'd4    // tail past entry detector, still over far detector
    } phase_e;

    typedef struct packed {
        dir_e   dir;
        phase_e ph;
    } track_t;

endpackage

// File: rtl/xing_side_sel.sv
// Maps the two physical detectors onto entry-side (near) and far-side
// views for the direction being tracked.
// Assumes: dir is only meaningful while a train is tracked.
module xing_side_sel
    import xing_pkg::*;
(
    input  dir_e dir,
    input  logic det_a,
    input  logic det_b,
    output logic near_on,
    output logic far_on
);

    // Purpose: swap detector roles according to the entry side.
    always_comb begin
        if (dir == FROM_A) begin
            near_on = det_a;
            far_on  = det_b;
        end else begin
            near_on = det_b;
            far_on  = det_a;
        end
    end

endmodule

// File: rtl/xing_phase_next.sv
// Next-phase logic, written once in direction-neutral terms.
// Assumes: near_on/far_on are already oriented to the tracked direction;
// any_on is the raw OR of both detectors, used only from idle.
module xing_phase_next
    import xing_pkg::*;
(
    input  phase_e ph,
    input  logic   any_on,
    input  logic   near_on,
    input  logic   far_on,
    output phase_e ph_n
);

    // Purpose: advance the progress phase from the oriented detector levels.
    always_comb begin
        ph_n = ph;
        case (ph)
            PH_IDLE: begin
                if (any_on) ph_n = PH_ENTER;
            end
            PH_ENTER: begin
                if (near_on && far_on)        ph_n = PH_SPAN;
                else if (!near_on && far_on)  ph_n = PH_EXIT;
                else if (!near_on && !far_on) ph_n = PH_GAP;
            end
            PH_GAP: begin
                if (far_on) ph_n = PH_EXIT;
            end
            PH_SPAN: begin
                if (!near_on && far_on)       ph_n = PH_EXIT;
                else if (!near_on && !far_on) ph_n = PH_IDLE;
            end
            PH_EXIT: begin
                if (!far_on) ph_n = PH_IDLE;
            end
            default: ph_n = PH_IDLE;
        endcase
    end

endmodule

// File: rtl/xing_track.sv
// Tracking register: holds entry side and phase, and chooses the entry
// side when a train first appears (side A wins a tie).
// Assumes: synchronous active-low reset.
module xing_track
    import xing_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   det_a,
    input  phase_e ph_n,
    output track_t st
);

    dir_e   dir_q;
    phase_e ph_q;

    // Purpose: register phase and latch entry side on leaving idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            dir_q <= FROM_A;
        end else begin
            ph_q <= ph_n;
            if (ph_q == PH_IDLE && ph_n != PH_IDLE)
                dir_q <= det_a ? FROM_A : FROM_B;
        end
    end

    assign st = '{dir: dir_q, ph: ph_q};

endmodule

// File: rtl/xing_gate_ctrl.sv
// Crossing gate controller top. gate_lower is high whenever a train is
// tracked. Detectors are level inputs, already synchronous to clk.
module xing_gate_ctrl
    import xing_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic det_a,
    input  logic det_b,
    output logic gate_lower
);

    track_t st_q;
    phase_e ph_n;
    logic   near_on;
    logic   far_on;
    logic   any_on;

    assign any_on = det_a | det_b;

    xing_side_sel u_sel (
        .dir     (st_q.dir),
        .det_a   (det_a),
        .det_b   (det_b),
        .near_on (near_on),
        .far_on  (far_on)
    );

    xing_phase_next u_next (
        .ph      (st_q.ph),
        .any_on  (any_on),
        .near_on (near_on),
        .far_on  (far_on),
        .ph_n    (ph_n)
    );

    xing_track u_trk (
        .clk   (clk),
        .rst_n (rst_n),
        .det_a (det_a),
        .ph_n  (ph_n),
        .st    (st_q)
    );

    // Purpose: gates down in every phase except idle.
    always_comb gate_lower = (st_q.ph != PH_IDLE);

endmodule

// File: rtl/xing_gate_chk.sv
// Property checker for the crossing gate controller, bound to the top.
// Assumes detector levels describe one train at a time.
module xing_gate_chk
    import xing_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   det_a,
    input logic   det_b,
    input logic   gate_lower,
    input track_t st
);

    AST_RESET_RAISES: assert property (@(posedge clk)
        !rst_n |=> !gate_lower); // R1

    AST_IDLE_STAYS_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_lower && !det_a && !det_b) |=> !gate_lower); // R2

    AST_ENTRY_SIDE_A: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_lower && det_a) |=> (gate_lower && st.dir == FROM_A)); // R3

    AST_ENTRY_SIDE_B: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_lower && det_b && !det_a) |=> (gate_lower && st.dir == FROM_B)); // R4

    AST_GAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st.ph == PH_GAP && !det_a && !det_b) |=> gate_lower); // R5

    AST_SPAN_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (st.ph == PH_SPAN) |=> (st.ph != PH_ENTER && st.ph != PH_GAP && $stable(st.dir))); // R6

    AST_EXIT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (st.ph == PH_EXIT && ((st.dir == FROM_A) ? !det_b : !det_a)) |=> !gate_lower); // R7

endmodule

bind xing_gate_ctrl xing_gate_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .det_a      (det_a),
    .det_b      (det_b),
    .gate_lower (gate_lower),
    .st         (st_q)
);

// File: tb/sim_xing_gate_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues the expected gate level per cycle,
// the monitor compares just after each rising edge.
module sim_xing_gate_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic det_a = 1'b0;
    logic det_b = 1'b0;
    logic gate_lower;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    bit    q_exp[$];
    string q_tag[$];

    always #2.5 clk = ~clk;

    xing_gate_ctrl u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .det_a      (det_a),
        .det_b      (det_b),
        .gate_lower (gate_lower)
    );

    // Purpose: monitor pops one expectation per clock and compares.
    always @(posedge clk) begin
        #1;
        if (q_exp.size() > 0) begin
            bit    e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            n_chk++;
            if (gate_lower !== e) begin
                n_err++;
                $display("FAIL %s: gate_lower=%0b expected=%0b at %0t", t, gate_lower, e, $time);
            end
        end
    end

    // Purpose: drive one cycle of inputs and queue the expected output.
    task automatic step(input bit r, input bit a, input bit b, input bit e, input string tag);
        @(negedge clk);
        rst_n = r;
        det_a = a;
        det_b = b;
        q_exp.push_back(e);
        q_tag.push_back(tag);
    endtask

    // Purpose: one train; from_b selects side, counts are from the front at the entry detector.
    task automatic train(input bit from_b, input int t_front_far, input int t_tail_near,
                         input int t_tail_far, input string tag);
        for (int t = 0; t <= t_tail_far; t++) begin
            bit nr;
            bit fr;
            nr = (t < t_tail_near);
            fr = (t >= t_front_far) && (t < t_tail_far);
            if (from_b) step(1'b1, fr, nr, (t < t_tail_far), tag);
            else        step(1'b1, nr, fr, (t < t_tail_far), tag);
        end
    endtask

    task automatic e2w_long(input int f, input int n, input int l);  train(1'b0, f, n, l, "R6"); endtask
    task automatic e2w_short(input int f, input int n, input int l); train(1'b0, f, n, l, "R5"); endtask
    task automatic w2e_long(input int f, input int n, input int l);  train(1'b1, f, n, l, "R6"); endtask
    task automatic w2e_short(input int f, input int n, input int l); train(1'b1, f, n, l, "R5"); endtask

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 1'b0, "R1");
        // R2: idle stays up
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R2");
        // R3 entry from A, short train then long trains
        step(1'b1, 1'b1, 1'b0, 1'b1, "R3");
        step(1'b1, 1'b0, 1'b0, 1'b1, "R5");
        step(1'b1, 1'b0, 1'b1, 1'b1, "R7");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R7");
        e2w_short(6, 3, 9);
        e2w_long(2, 7, 10);
        e2w_long(1, 12, 13);
        // R4 entry from B
        step(1'b1, 1'b0, 1'b1, 1'b1, "R4");
        step(1'b1, 1'b0, 1'b0, 1'b1, "R5");
        step(1'b1, 1'b1, 1'b0, 1'b1, "R7");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R7");
        w2e_short(8, 2, 11);
        w2e_long(3, 9, 12);
        // R7: exactly spacing-length train, near off as far on
        train(1'b0, 4, 4, 7, "R7");
        // R8: back to back, opposite sides
        train(1'b0, 2, 5, 7, "R8");
        train(1'b1, 5, 2, 8, "R8");
        train(1'b1, 1, 3, 4, "R8");
        // R9: both rise together
        train(1'b0, 0, 4, 6, "R9");
        // R1: reset in the middle of a train
        step(1'b1, 1'b1, 1'b0, 1'b1, "R3");
        step(1'b1, 1'b1, 1'b1, 1'b1, "R6");
        step(1'b0, 1'b1, 1'b1, 1'b0, "R1");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R1");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R2");
        // drain
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    // Purpose: watchdog against a hung run.
    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1'b1;
            n_err++;
            n_chk++;
            $display("FAIL watchdog: finished=0 expected=1");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule